// File: doc/BRIEF.md
# Bidirectional Slotted Token Ring

This block links a parameterised number of processing elements through two shift-register rings that rotate in opposite directions. Each ring holds exactly one slot per element, and a slot is either empty or carries a single token made of a destination index, a 16-bit tag and a 16-bit value. Both rings advance one position on every clock, so a token moves one element further each cycle until it reaches the element it is addressed to. That element takes it off the ring at once.

Each element hands tokens to the ring through a one-entry send register with a valid/ready handshake. When a token is accepted, the register picks the ring that gives the shorter path to the destination. It then waits for an empty slot to pass in front of the element on that ring. A slot emptied by a delivery at that element counts as empty in the same cycle. Delivery cannot be refused: each element has one registered receive output per ring, so two tokens that arrive in the same cycle are both presented. Matching tokens inside the elements is outside this block.

Top module: `tring_top`

## Requirements
- R1: After reset, all receive valid outputs are 0, every `tx_ready` bit is 1, and no token is delivered until one is sent.
- R2: Element indices increase in the clockwise direction. For a token sent from element s to element d with clockwise distance k = (d - s) mod N and 1 <= k <= N/2, the token arrives on the clockwise receive output of d. Otherwise it arrives on the counter-clockwise receive output, having travelled N - k hops. A tie at k = N/2 goes clockwise.
- R3: A token addressed to its own sender travels a full lap of N hops on the clockwise ring and is delivered back to the sender.
- R4: If the slot in front of the sender on the chosen ring is empty, a token accepted on clock edge A shows at its destination's receive output right after edge A + 1 + hops.
- R5: Each accepted token is delivered exactly once, with its tag and value unchanged. It appears on no other element and on no other ring output. Slots passing through other elements are not altered.
- R6: Delivery is mandatory. A token that reaches its destination is presented on that element's receive output for exactly one cycle, starting the next cycle, and no input can hold it back.
- R7: When tokens on both rings reach the same element in the same cycle, both are presented in the same cycle, one on each receive output.
- R8: A waiting token is inserted only into a slot that is empty. A token passing through has priority, and while the send register is full and no free slot is in front of it, `tx_ready` is 0 and the waiting token is delayed by one cycle for each occupied slot.
- R9: A slot freed by a delivery at an element can take that element's waiting token in the same cycle.
- R10: `tx_ready` is 1 in any cycle in which the send register is empty or its token is being inserted, so one element can send one token per cycle without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | N_NODES | Per-element send request |
| tx_ready | output | N_NODES | Per-element send register can take a token |
| tx_dest | input | N_NODES*DEST_W | Per-element destination index |
| tx_tag | input | N_NODES*TAG_W | Per-element token tag |
| tx_value | input | N_NODES*VAL_W | Per-element token value |
| rx_cw_valid | output | N_NODES | Token delivered from the clockwise ring |
| rx_cw_tag | output | N_NODES*TAG_W | Tag of the clockwise delivery |
| rx_cw_value | output | N_NODES*VAL_W | Value of the clockwise delivery |
| rx_ccw_valid | output | N_NODES | Token delivered from the counter-clockwise ring |
| rx_ccw_tag | output | N_NODES*TAG_W | Tag of the counter-clockwise delivery |
| rx_ccw_value | output | N_NODES*VAL_W | Value of the counter-clockwise delivery |

## Verification
The bench uses the default build: four elements with 16-bit tags and values. With four elements, every source/destination pair is covered: one-hop paths on both rings, the two-hop tie that must go clockwise, and the four-hop self lap. Four elements are also few enough to set up by hand a double arrival at one element, a sender blocked by a passing token, and a slot that is freed and refilled in the same cycle.

// File: rtl/tring_pkg.sv
package tring_pkg;

  typedef enum logic {
    RING_CW  = 1'b0,
    RING_CCW = 1'b1
  } ring_sel_e;

  // Hops from src to dst moving in the direction of rising index.
  function automatic int unsigned cw_distance(int unsigned src, int unsigned dst,
                                              int unsigned n);
    return (dst + n - src) % n;
  endfunction

  // Shorter path wins; a tie and a self-addressed token go clockwise.
  function automatic ring_sel_e choose_ring(int unsigned src, int unsigned dst,
                                            int unsigned n);
    if (cw_distance(src, dst, n) <= n / 2) return RING_CW;
    return RING_CCW;
  endfunction

endpackage

// File: rtl/tring_sender.sv
module tring_sender
  import tring_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int NODE_IDX = 0,
  parameter int DEST_W   = 2,
  parameter int TAG_W    = 16,
  parameter int VAL_W    = 16,
  localparam int SLOT_W  = 1 + DEST_W + TAG_W + VAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DEST_W-1:0] tx_dest,
  input  logic [TAG_W-1:0]  tx_tag,
  input  logic [VAL_W-1:0]  tx_value,
  input  logic              grant_cw,
  input  logic              grant_ccw,
  output logic              req_cw,
  output logic              req_ccw,
  output logic [SLOT_W-1:0] req_slot
);

  logic              full_q;
  ring_sel_e         dir_q;
  logic [SLOT_W-1:0] slot_q;
  logic              ins_fire;

  assign req_cw   = full_q && (dir_q == RING_CW);
  assign req_ccw  = full_q && (dir_q == RING_CCW);
  assign req_slot = slot_q;
  assign ins_fire = (dir_q == RING_CW) ? grant_cw : grant_ccw;
  assign tx_ready = !full_q || ins_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      dir_q  <= RING_CW;
      slot_q <= '0;
    end else if (tx_valid && tx_ready) begin
      full_q <= 1'b1;
      dir_q  <= choose_ring(NODE_IDX, 32'(tx_dest), N_NODES);
      slot_q <= {1'b1, tx_dest, tx_tag, tx_value};
    end else if (ins_fire) begin
      full_q <= 1'b0;
    end
  end

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (full_q && !ins_fire) |=> (full_q && $stable(slot_q) && $stable(dir_q)))
    else $error("waiting token changed before insertion"); // R8

endmodule

// File: rtl/tring_stage.sv
module tring_stage #(
  parameter int NODE_IDX = 0,
  parameter int DEST_W   = 2,
  parameter int TAG_W    = 16,
  parameter int VAL_W    = 16,
  localparam int SLOT_W  = 1 + DEST_W + TAG_W + VAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic              ins_req,
  input  logic [SLOT_W-1:0] ins_slot,
  output logic              ins_grant,
  output logic [SLOT_W-1:0] slot_out,
  output logic              rx_valid,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [VAL_W-1:0]  rx_value
);

  localparam int TAG_LO  = VAL_W;
  localparam int DEST_LO = VAL_W + TAG_W;
  localparam int VLD_B   = SLOT_W - 1;
  localparam logic [DEST_W-1:0] MY_ID = DEST_W'(NODE_IDX);

  logic              in_vld;
  logic [DEST_W-1:0] in_dest;
  logic              arrive;
  logic              slot_free;

  assign in_vld    = slot_in[VLD_B];
  assign in_dest   = slot_in[DEST_LO +: DEST_W];
  assign arrive    = in_vld && (in_dest == MY_ID);
  assign slot_free = !in_vld || arrive;
  assign ins_grant = ins_req && slot_free;

  always_comb begin
    if (ins_grant)   slot_out = ins_slot;
    else if (arrive) slot_out = '0;
    else             slot_out = slot_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_tag   <= '0;
      rx_value <= '0;
    end else begin
      rx_valid <= arrive;
      if (arrive) begin
        rx_tag   <= slot_in[TAG_LO +: TAG_W];
        rx_value <= slot_in[0 +: VAL_W];
      end
    end
  end

endmodule

// File: rtl/tring_ring.sv
module tring_ring #(
  parameter int N_NODES   = 4,
  parameter int DEST_W    = 2,
  parameter int TAG_W     = 16,
  parameter int VAL_W     = 16,
  parameter bit CLOCKWISE = 1'b1,
  localparam int SLOT_W   = 1 + DEST_W + TAG_W + VAL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_NODES-1:0]         ins_req,
  input  logic [N_NODES*SLOT_W-1:0]  ins_slot,
  output logic [N_NODES-1:0]         ins_grant,
  output logic [N_NODES-1:0]         rx_valid,
  output logic [N_NODES*TAG_W-1:0]   rx_tag,
  output logic [N_NODES*VAL_W-1:0]   rx_value
);

  localparam int TAG_LO  = VAL_W;
  localparam int DEST_LO = VAL_W + TAG_W;
  localparam int VLD_B   = SLOT_W - 1;

  logic [SLOT_W-1:0] slot_q    [N_NODES];
  logic [SLOT_W-1:0] slot_d    [N_NODES];
  logic [SLOT_W-1:0] stage_out [N_NODES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_NODES; i++) begin
      if (rst) slot_q[i] <= '0;
      else     slot_q[i] <= slot_d[i];
    end
  end

  for (genvar g = 0; g < N_NODES; g++) begin : g_pos
    localparam int NXT = CLOCKWISE ? (g + 1) % N_NODES : (g + N_NODES - 1) % N_NODES;
    localparam int PRV = CLOCKWISE ? (g + N_NODES - 1) % N_NODES : (g + 1) % N_NODES;

    tring_stage #(
      .NODE_IDX (g),
      .DEST_W   (DEST_W),
      .TAG_W    (TAG_W),
      .VAL_W    (VAL_W)
    ) u_stage (
      .clk       (clk),
      .rst       (rst),
      .slot_in   (slot_q[g]),
      .ins_req   (ins_req[g]),
      .ins_slot  (ins_slot[g*SLOT_W +: SLOT_W]),
      .ins_grant (ins_grant[g]),
      .slot_out  (stage_out[g]),
      .rx_valid  (rx_valid[g]),
      .rx_tag    (rx_tag[g*TAG_W +: TAG_W]),
      .rx_value  (rx_value[g*VAL_W +: VAL_W])
    );

    assign slot_d[g] = stage_out[PRV];

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (slot_q[g][VLD_B] && (slot_q[g][DEST_LO +: DEST_W] != DEST_W'(g)))
        |=> (slot_q[NXT] == $past(slot_q[g])))
      else $error("token altered or lost while passing an element"); // R5

    AST_RX_DATA: assert property (@(posedge clk) disable iff (rst)
      rx_valid[g] |-> ((rx_tag[g*TAG_W +: TAG_W] == $past(slot_q[g][TAG_LO +: TAG_W])) &&
                       (rx_value[g*VAL_W +: VAL_W] == $past(slot_q[g][0 +: VAL_W]))))
      else $error("delivered data differs from the arriving slot"); // R6

    AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (rst)
      ins_grant[g] |=> (slot_q[NXT] == $past(ins_slot[g*SLOT_W +: SLOT_W])))
      else $error("granted token did not enter the ring"); // R9
  end

endmodule

// File: rtl/tring_top.sv
module tring_top #(
  parameter int N_NODES = 4,
  parameter int TAG_W   = 16,
  parameter int VAL_W   = 16,
  localparam int DEST_W = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int SLOT_W = 1 + DEST_W + TAG_W + VAL_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_NODES-1:0]        tx_valid,
  output logic [N_NODES-1:0]        tx_ready,
  input  logic [N_NODES*DEST_W-1:0] tx_dest,
  input  logic [N_NODES*TAG_W-1:0]  tx_tag,
  input  logic [N_NODES*VAL_W-1:0]  tx_value,
  output logic [N_NODES-1:0]        rx_cw_valid,
  output logic [N_NODES*TAG_W-1:0]  rx_cw_tag,
  output logic [N_NODES*VAL_W-1:0]  rx_cw_value,
  output logic [N_NODES-1:0]        rx_ccw_valid,
  output logic [N_NODES*TAG_W-1:0]  rx_ccw_tag,
  output logic [N_NODES*VAL_W-1:0]  rx_ccw_value
);

  logic [N_NODES-1:0]        req_cw;
  logic [N_NODES-1:0]        req_ccw;
  logic [N_NODES-1:0]        grant_cw;
  logic [N_NODES-1:0]        grant_ccw;
  logic [N_NODES*SLOT_W-1:0] req_slot;

  for (genvar n = 0; n < N_NODES; n++) begin : g_send
    tring_sender #(
      .N_NODES  (N_NODES),
      .NODE_IDX (n),
      .DEST_W   (DEST_W),
      .TAG_W    (TAG_W),
      .VAL_W    (VAL_W)
    ) u_sender (
      .clk       (clk),
      .rst       (rst),
      .tx_valid  (tx_valid[n]),
      .tx_ready  (tx_ready[n]),
      .tx_dest   (tx_dest[n*DEST_W +: DEST_W]),
      .tx_tag    (tx_tag[n*TAG_W +: TAG_W]),
      .tx_value  (tx_value[n*VAL_W +: VAL_W]),
      .grant_cw  (grant_cw[n]),
      .grant_ccw (grant_ccw[n]),
      .req_cw    (req_cw[n]),
      .req_ccw   (req_ccw[n]),
      .req_slot  (req_slot[n*SLOT_W +: SLOT_W])
    );
  end

  tring_ring #(
    .N_NODES   (N_NODES),
    .DEST_W    (DEST_W),
    .TAG_W     (TAG_W),
    .VAL_W     (VAL_W),
    .CLOCKWISE (1'b1)
  ) u_ring_cw (
    .clk       (clk),
    .rst       (rst),
    .ins_req   (req_cw),
    .ins_slot  (req_slot),
    .ins_grant (grant_cw),
    .rx_valid  (rx_cw_valid),
    .rx_tag    (rx_cw_tag),
    .rx_value  (rx_cw_value)
  );

  tring_ring #(
    .N_NODES   (N_NODES),
    .DEST_W    (DEST_W),
    .TAG_W     (TAG_W),
    .VAL_W     (VAL_W),
    .CLOCKWISE (1'b0)
  ) u_ring_ccw (
    .clk       (clk),
    .rst       (rst),
    .ins_req   (req_ccw),
    .ins_slot  (req_slot),
    .ins_grant (grant_ccw),
    .rx_valid  (rx_ccw_valid),
    .rx_tag    (rx_ccw_tag),
    .rx_value  (rx_ccw_value)
  );

endmodule

// File: tb/tring_top_tb.sv
module tring_top_tb;

  localparam int N          = 4;
  localparam int TW         = 16;
  localparam int VW         = 16;
  localparam int DW         = 2;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_MAX    = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]    tx_valid;
  logic [N-1:0]    tx_ready;
  logic [N*DW-1:0] tx_dest;
  logic [N*TW-1:0] tx_tag;
  logic [N*VW-1:0] tx_value;
  logic [N-1:0]    rx_cw_valid;
  logic [N*TW-1:0] rx_cw_tag;
  logic [N*VW-1:0] rx_cw_value;
  logic [N-1:0]    rx_ccw_valid;
  logic [N*TW-1:0] rx_ccw_tag;
  logic [N*VW-1:0] rx_ccw_value;

  tring_top #(.N_NODES(N), .TAG_W(TW), .VAL_W(VW)) u_dut (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dest(tx_dest),
    .tx_tag(tx_tag), .tx_value(tx_value),
    .rx_cw_valid(rx_cw_valid), .rx_cw_tag(rx_cw_tag), .rx_cw_value(rx_cw_value),
    .rx_ccw_valid(rx_ccw_valid), .rx_ccw_tag(rx_ccw_tag), .rx_ccw_value(rx_ccw_value)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Delivery log filled by a monitor on the falling edge.
  int          log_n = 0;
  int          log_node [LOG_MAX];
  int          log_ring [LOG_MAX];
  int          log_cyc  [LOG_MAX];
  logic [15:0] log_tag  [LOG_MAX];
  logic [15:0] log_val  [LOG_MAX];

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (rx_cw_valid[i] && log_n < LOG_MAX) begin
          log_node[log_n] = i; log_ring[log_n] = 0; log_cyc[log_n] = cyc;
          log_tag[log_n] = rx_cw_tag[i*TW +: TW]; log_val[log_n] = rx_cw_value[i*VW +: VW];
          log_n++;
        end
        if (rx_ccw_valid[i] && log_n < LOG_MAX) begin
          log_node[log_n] = i; log_ring[log_n] = 1; log_cyc[log_n] = cyc;
          log_tag[log_n] = rx_ccw_tag[i*TW +: TW]; log_val[log_n] = rx_ccw_value[i*VW +: VW];
          log_n++;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_tx(int i, int d, logic [15:0] t, logic [15:0] v);
    tx_valid[i] = 1'b1;
    tx_dest[i*DW +: DW] = DW'(d);
    tx_tag[i*TW +: TW] = t;
    tx_value[i*VW +: VW] = v;
  endtask

  task automatic clear_tx();
    tx_valid = '0;
  endtask

  // Ring and path length from the requirements: 0 = clockwise, 1 = counter-clockwise.
  function automatic int ring_of(int s, int d);
    int k = (d - s + N) % N;
    return (k <= N/2) ? 0 : 1;
  endfunction

  function automatic int hops_of(int s, int d);
    int k = (d - s + N) % N;
    if (k == 0) return N;
    return (k <= N/2) ? k : N - k;
  endfunction

  task automatic expect_tok(string rq_ring, string rq_cyc, logic [15:0] tag, logic [15:0] val,
                            int node, int ring, int at);
    int cnt = 0;
    int idx = 0;
    for (int e = 0; e < log_n; e++) begin
      if (log_tag[e] == tag) begin
        cnt++;
        idx = e;
      end
    end
    check(cnt == 1, "R5", "deliveries of one token", cnt, 1);
    if (cnt == 1) begin
      check(log_node[idx] == node, "R5", "destination element", log_node[idx], node);
      check(log_ring[idx] == ring, rq_ring, "receive ring", log_ring[idx], ring);
      check(log_cyc[idx] == at, rq_cyc, "delivery cycle", log_cyc[idx], at);
      check(log_val[idx] == val, "R5", "delivered value", int'(log_val[idx]), int'(val));
    end
  endtask

  task automatic test_reset();
    check(tx_ready == '1, "R1", "tx_ready after reset", int'(tx_ready), (1 << N) - 1);
    check(rx_cw_valid == '0 && rx_ccw_valid == '0, "R1", "receive valids after reset",
          int'({rx_cw_valid, rx_ccw_valid}), 0);
    log_n = 0;
    repeat (6) @(negedge clk);
    check(log_n == 0, "R1", "deliveries from an idle ring", log_n, 0);
  endtask

  // R2, R3, R4, R5: every source/destination pair on an otherwise idle ring.
  task automatic test_all_pairs();
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        logic [15:0] t = 16'hA000 + 16'(s*16 + d);
        int acc;
        log_n = 0;
        set_tx(s, d, t, ~t);
        check(tx_ready[s], "R10", "ready of an idle sender", int'(tx_ready[s]), 1);
        @(negedge clk);
        acc = cyc;
        clear_tx();
        repeat (2*N + 4) @(negedge clk);
        expect_tok((s == d) ? "R3" : "R2", "R4", t, ~t, d, ring_of(s, d), acc + 1 + hops_of(s, d));
        check(log_n == 1, "R5", "total deliveries", log_n, 1);
      end
    end
  endtask

  // R7: tokens reach element 2 on both rings in the same cycle.
  task automatic test_dual_arrival();
    int acc;
    log_n = 0;
    set_tx(1, 2, 16'hB001, 16'h1111);
    set_tx(3, 2, 16'hB003, 16'h3333);
    @(negedge clk);
    acc = cyc;
    clear_tx();
    repeat (2*N + 4) @(negedge clk);
    expect_tok("R7", "R7", 16'hB001, 16'h1111, 2, 0, acc + 2);
    expect_tok("R7", "R7", 16'hB003, 16'h3333, 2, 1, acc + 2);
  endtask

  // R8: element 1 waits while element 0's token passes in front of it.
  task automatic test_blocked();
    int acc0;
    int acc1;
    log_n = 0;
    set_tx(0, 2, 16'hC000, 16'h0C0C);
    @(negedge clk);
    acc0 = cyc;
    clear_tx();
    set_tx(1, 3, 16'hC001, 16'h1C1C);
    @(negedge clk);
    acc1 = cyc;
    clear_tx();
    check(!tx_ready[1], "R8", "ready while a token passes", int'(tx_ready[1]), 0);
    @(negedge clk);
    check(tx_ready[1], "R10", "ready while inserting", int'(tx_ready[1]), 1);
    repeat (2*N + 4) @(negedge clk);
    expect_tok("R2", "R4", 16'hC000, 16'h0C0C, 2, 0, acc0 + 3);
    expect_tok("R2", "R8", 16'hC001, 16'h1C1C, 3, 0, acc1 + 4);
  endtask

  // R9: element 1 reuses the slot its own delivery frees.
  task automatic test_reuse();
    int acc0;
    int acc1;
    log_n = 0;
    set_tx(0, 1, 16'hD000, 16'h0D0D);
    @(negedge clk);
    acc0 = cyc;
    clear_tx();
    set_tx(1, 2, 16'hD001, 16'h1D1D);
    @(negedge clk);
    acc1 = cyc;
    clear_tx();
    check(tx_ready[1], "R9", "ready when the freed slot is taken", int'(tx_ready[1]), 1);
    repeat (2*N + 4) @(negedge clk);
    expect_tok("R2", "R4", 16'hD000, 16'h0D0D, 1, 0, acc0 + 2);
    expect_tok("R2", "R9", 16'hD001, 16'h1D1D, 2, 0, acc1 + 2);
  endtask

  // R10: three tokens from one element on consecutive cycles.
  task automatic test_back_to_back();
    int acc [3];
    log_n = 0;
    for (int k = 0; k < 3; k++) begin
      set_tx(2, 3, 16'hE000 + 16'(k), 16'h00E0 + 16'(k));
      check(tx_ready[2], "R10", "ready on a back-to-back send", int'(tx_ready[2]), 1);
      @(negedge clk);
      acc[k] = cyc;
    end
    clear_tx();
    repeat (2*N + 4) @(negedge clk);
    for (int k = 0; k < 3; k++)
      expect_tok("R2", "R10", 16'hE000 + 16'(k), 16'h00E0 + 16'(k), 3, 0, acc[k] + 2);
    check(log_n == 3, "R10", "total deliveries", log_n, 3);
  endtask

  // R6: every element sends to element 0 at once; each token is taken exactly once.
  task automatic test_all_to_one();
    int acc;
    log_n = 0;
    for (int s = 0; s < N; s++) set_tx(s, 0, 16'hF000 + 16'(s), 16'h0F00 + 16'(s));
    @(negedge clk);
    acc = cyc;
    clear_tx();
    repeat (2*N + 4) @(negedge clk);
    for (int s = 0; s < N; s++)
      expect_tok((s == 0) ? "R3" : "R2", "R6", 16'hF000 + 16'(s), 16'h0F00 + 16'(s), 0,
                 ring_of(s, 0), acc + 1 + hops_of(s, 0));
    check(log_n == N, "R6", "one-cycle delivery pulses", log_n, N);
  endtask

  initial begin
    tx_valid = '0;
    tx_dest  = '0;
    tx_tag   = '0;
    tx_value = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_all_pairs();
    test_dual_arrival();
    test_blocked();
    test_reuse();
    test_back_to_back();
    test_all_to_one();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule